// File: doc/BRIEF.md
# Overflow Trap Entry and Interrupt Return Sequencer

This block sits beside the execution unit of a 16-bit processor core and performs two stack-based control transfers on command. A trap-entry command conditionally enters the overflow handler. If the overflow flag is clear, nothing happens. If it is set, the block pushes the flag word, the code segment and the instruction pointer, and then fetches a new code segment and instruction pointer from a fixed vector slot in low memory. A return command pops the instruction pointer, the code segment and the flag word, in that order.

When a command is accepted, the block loads its working copy of the stack pointer, stack segment, code segment, instruction pointer and flags from input ports. It presents the results on matching output ports. Every memory access is one 16-bit word moved over a request/acknowledge pair. The core starts an operation with a one-cycle command pulse and waits for the done pulse.

Top module: `trap_seq`

## Requirements
- R1: After reset, busy, done and mem_req are all low.
- R2: A trap-entry command accepted while FLAGS bit 11 (overflow) is 0 makes no memory request. It raises done in the first cycle after acceptance, and the register outputs equal the values loaded at acceptance.
- R3: With overflow set, entry writes three words at physical address (SS<<4)+SP. SP is first lowered by 2 for each write. The words are FLAGS, then CS, then IP, so SP ends 6 lower.
- R4: Once the flag word has been written, FLAGS bits 9 (interrupt enable) and 8 (trace) read 0. The saved stack copy keeps their earlier values.
- R5: After the pushes, entry reads CS from physical address 0x00012 and then IP from 0x00010. These are the slots of vector type 4.
- R6: A return command reads IP at (SS<<4)+SP, then CS, then FLAGS. SP is raised by 2 after each read. The restored word replaces every flag bit, including bits 9 and 8.
- R7: A request, together with its address, direction and write data, is held unchanged until mem_ack. No register output changes without an acknowledge.
- R8: busy is high from the cycle after acceptance through the one-cycle done pulse. Commands that arrive while busy is high are ignored.
- R9: If both commands arrive in the same idle cycle, the trap entry is performed.
- R10: SP arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_req | input | 1 | Start conditional overflow trap entry |
| return_req | input | 1 | Start interrupt return |
| sp_in | input | 16 | Stack pointer loaded at acceptance |
| ss_in | input | 16 | Stack segment loaded at acceptance |
| cs_in | input | 16 | Code segment loaded at acceptance |
| ip_in | input | 16 | Instruction pointer loaded at acceptance |
| flags_in | input | 16 | Flag word loaded at acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 16 | Current stack pointer |
| ss | output | 16 | Current stack segment |
| cs | output | 16 | Current code segment |
| ip | output | 16 | Current instruction pointer |
| flags | output | 16 | Current flag word |
| mem_req | output | 1 | Word access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address of the word (low byte) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
A corrupted sequencer state shows up in the same cycle as a request with the wrong address, direction or data, or as a missing or extra request, because the request signals are decoded directly from the state. A wrong stack pointer step appears on the next request address, and on the sp output one cycle after the acknowledge. A wrongly cleared or retained flag bit can be seen on flags as soon as the first push is acknowledged. An early or late done shows as a one-cycle mismatch against the bench's reference model.

// File: rtl/trap_seq.sv
module trap_seq #(
  parameter int VEC_TYPE = 4,
  parameter int OF_BIT   = 11,
  parameter int IE_BIT   = 9,
  parameter int TR_BIT   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        entry_req,
  input  logic        return_req,
  input  logic [15:0] sp_in,
  input  logic [15:0] ss_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] ip_in,
  input  logic [15:0] flags_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] sp,
  output logic [15:0] ss,
  output logic [15:0] cs,
  output logic [15:0] ip,
  output logic [15:0] flags,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack
);
  localparam logic [19:0] VEC_IP_ADDR = 20'(VEC_TYPE * 4);
  localparam logic [19:0] VEC_CS_ADDR = VEC_IP_ADDR + 20'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_PF, S_PC, S_PI, S_VC, S_VI, S_RI, S_RC, S_RF, S_FIN
  } st_t;

  st_t state;
  logic push, pop, vec;
  logic [15:0] sp_dn, sp_up;

  assign push  = state inside {S_PF, S_PC, S_PI};
  assign pop   = state inside {S_RI, S_RC, S_RF};
  assign vec   = state inside {S_VC, S_VI};
  assign sp_dn = sp - 16'd2;
  assign sp_up = sp + 16'd2;

  assign busy    = state != S_IDLE;
  assign done    = state == S_FIN;
  assign mem_req = push | pop | vec;
  assign mem_we  = push;
  assign mem_addr = vec ? ((state == S_VC) ? VEC_CS_ADDR : VEC_IP_ADDR)
                        : {ss, 4'b0} + {4'b0, push ? sp_dn : sp};

  always_comb begin
    case (state)
      S_PF:    mem_wdata = flags;
      S_PC:    mem_wdata = cs;
      S_PI:    mem_wdata = ip;
      default: mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sp <= '0; ss <= '0; cs <= '0; ip <= '0; flags <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (entry_req || return_req) begin
            sp <= sp_in; ss <= ss_in; cs <= cs_in; ip <= ip_in; flags <= flags_in;
            if (entry_req) state <= flags_in[OF_BIT] ? S_PF : S_FIN;
            else           state <= S_RI;
          end
        S_PF: if (mem_ack) begin
          sp <= sp_dn;
          flags[IE_BIT] <= 1'b0;
          flags[TR_BIT] <= 1'b0;
          state <= S_PC;
        end
        S_PC: if (mem_ack) begin sp <= sp_dn; state <= S_PI; end
        S_PI: if (mem_ack) begin sp <= sp_dn; state <= S_VC; end
        S_VC: if (mem_ack) begin cs <= mem_rdata; state <= S_VI; end
        S_VI: if (mem_ack) begin ip <= mem_rdata; state <= S_FIN; end
        S_RI: if (mem_ack) begin ip <= mem_rdata; sp <= sp_up; state <= S_RC; end
        S_RC: if (mem_ack) begin cs <= mem_rdata; sp <= sp_up; state <= S_RF; end
        S_RF: if (mem_ack) begin flags <= mem_rdata; sp <= sp_up; state <= S_FIN; end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_quiet_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
  p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> sp == $past(sp) - 16'd2);
  p_flags_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec |-> !flags[IE_BIT] && !flags[TR_BIT]);
  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && mem_ack |=> sp == $past(sp) + 16'd2);
  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_regs_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ack |=> $stable(sp) && $stable(cs) && $stable(ip) && $stable(flags));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
endmodule

// File: tb/test_trap_seq.sv
module test_trap_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, entry_req = 0, return_req = 0;
  logic [15:0] sp_in = 0, ss_in = 0, cs_in = 0, ip_in = 0, flags_in = 0;
  logic busy, done, mem_req, mem_we;
  logic [15:0] sp, ss, cs, ip, flags, mem_wdata;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata = 0;
  logic mem_ack = 0;

  trap_seq i_trap_seq (.clk, .rst_n, .entry_req, .return_req, .sp_in, .ss_in, .cs_in,
    .ip_in, .flags_in, .busy, .done, .sp, .ss, .cs, .ip, .flags, .mem_req, .mem_we,
    .mem_addr, .mem_wdata, .mem_rdata, .mem_ack);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef enum {K_PF, K_PC, K_PI, K_VC, K_VI, K_RI, K_RC, K_RF} kind_t;
  logic [15:0] memw [logic [19:0]];
  kind_t q[$];
  bit m_busy, m_done, finished;
  logic [15:0] m_sp, m_ss, m_cs, m_ip, m_flags;
  int vectors = 0, misses = 0, wait_n = 0, wcnt = 0;
  string cur_tag = "R1";

  function automatic logic [15:0] rd(input logic [19:0] a);
    return memw.exists(a) ? memw[a] : 16'h0;
  endfunction

  function automatic logic [19:0] exp_addr(input kind_t k);
    case (k)
      K_VC: return 20'h00012;
      K_VI: return 20'h00010;
      K_PF, K_PC, K_PI: return {m_ss, 4'b0} + {4'b0, m_sp - 16'd2};
      default: return {m_ss, 4'b0} + {4'b0, m_sp};
    endcase
  endfunction

  function automatic logic [15:0] exp_wdata(input kind_t k);
    return k == K_PF ? m_flags : k == K_PC ? m_cs : k == K_PI ? m_ip : 16'h0;
  endfunction

  function automatic string kind_tag(input kind_t k);
    return k inside {K_PF, K_PC, K_PI} ? "R3" : k inside {K_VC, K_VI} ? "R5" : "R6";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [19:0] act, input logic [19:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model: advances on the same edge as the design, from bench state only
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; q.delete();
      m_sp = 0; m_ss = 0; m_cs = 0; m_ip = 0; m_flags = 0;
    end else if (m_done) begin
      m_done = 0; m_busy = 0;
    end else if (m_busy) begin
      if (q.size() > 0 && mem_ack) begin
        case (q[0])
          K_PF: begin m_sp = m_sp - 16'd2; m_flags[9] = 1'b0; m_flags[8] = 1'b0; end
          K_PC, K_PI: m_sp = m_sp - 16'd2;
          K_VC: m_cs = rd(20'h00012);
          K_VI: m_ip = rd(20'h00010);
          K_RI: begin m_ip = rd(exp_addr(K_RI)); m_sp = m_sp + 16'd2; end
          K_RC: begin m_cs = rd(exp_addr(K_RC)); m_sp = m_sp + 16'd2; end
          K_RF: begin m_flags = rd(exp_addr(K_RF)); m_sp = m_sp + 16'd2; end
          default: ;
        endcase
        void'(q.pop_front());
        if (q.size() == 0) m_done = 1;
      end
    end else if (entry_req || return_req) begin
      m_sp = sp_in; m_ss = ss_in; m_cs = cs_in; m_ip = ip_in; m_flags = flags_in;
      m_busy = 1;
      if (entry_req) begin
        if (flags_in[11]) q = '{K_PF, K_PC, K_PI, K_VC, K_VI};
        else m_done = 1;
      end else q = '{K_RI, K_RC, K_RF};
    end
  end

  // Per-cycle comparison, then memory responder
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_req;
      exp_req = m_busy && !m_done && q.size() > 0;
      chk(busy == m_busy, "R8", "busy", 20'(busy), 20'(m_busy));
      chk(done == m_done, "R8", "done", 20'(done), 20'(m_done));
      chk(mem_req == exp_req, "R7", "mem_req", 20'(mem_req), 20'(exp_req));
      if (exp_req && mem_req) begin
        chk(mem_addr == exp_addr(q[0]), kind_tag(q[0]), "mem_addr", mem_addr, exp_addr(q[0]));
        chk(mem_we == (q[0] inside {K_PF, K_PC, K_PI}), kind_tag(q[0]), "mem_we",
            20'(mem_we), 20'(q[0] inside {K_PF, K_PC, K_PI}));
        if (mem_we)
          chk(mem_wdata == exp_wdata(q[0]), kind_tag(q[0]), "mem_wdata",
              20'(mem_wdata), 20'(exp_wdata(q[0])));
      end
      chk(sp == m_sp, cur_tag, "sp", 20'(sp), 20'(m_sp));
      chk(cs == m_cs, cur_tag, "cs", 20'(cs), 20'(m_cs));
      chk(ip == m_ip, cur_tag, "ip", 20'(ip), 20'(m_ip));
      chk(flags == m_flags, "R4", "flags", 20'(flags), 20'(m_flags));
      chk(ss == m_ss, cur_tag, "ss", 20'(ss), 20'(m_ss));
    end
    mem_ack = 0;
    if (rst_n && mem_req) begin
      if (wcnt >= wait_n) begin
        mem_ack = 1;
        mem_rdata = rd(mem_addr);
        if (mem_we) memw[mem_addr] = mem_wdata;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic start(input bit e, input bit r, input logic [15:0] s_p, input logic [15:0] s_s,
                       input logic [15:0] c_s, input logic [15:0] i_p, input logic [15:0] f);
    @(negedge clk);
    sp_in = s_p; ss_in = s_s; cs_in = c_s; ip_in = i_p; flags_in = f;
    entry_req = e; return_req = r;
    @(negedge clk);
    entry_req = 0; return_req = 0;
  endtask

  task automatic finish_op();
    int n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    memw[20'h00010] = 16'h1234;
    memw[20'h00012] = 16'hABCD;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk(!busy && !done && !mem_req, "R1", "outputs in reset", {busy, done, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", "outputs after reset", {busy, done, mem_req}, 0);

    // R2: overflow clear, immediate done, no access
    cur_tag = "R2";
    start(1, 0, 16'h0100, 16'h2000, 16'h3000, 16'h0040, 16'h0300);
    chk(done == 1 && !mem_req, "R2", "done right after accept", {done, mem_req}, 2'b10);
    finish_op();
    chk(sp == 16'h0100 && ip == 16'h0040 && cs == 16'h3000, "R2", "regs unchanged", 20'(sp), 20'h0100);

    // R3 R4 R5 R7: overflow set, wait states, IF/TF set
    cur_tag = "R3"; wait_n = 2;
    start(1, 0, 16'h0100, 16'h2000, 16'h3000, 16'h0040, 16'h0B00);
    finish_op();
    chk(memw[20'h200FE] == 16'h0B00, "R4", "saved flags keep IF/TF", memw[20'h200FE], 16'h0B00);
    chk(memw[20'h200FC] == 16'h3000, "R3", "saved cs", memw[20'h200FC], 16'h3000);
    chk(memw[20'h200FA] == 16'h0040, "R3", "saved ip", memw[20'h200FA], 16'h0040);
    chk(sp == 16'h00FA, "R3", "sp lowered by 6", 20'(sp), 20'h00FA);
    chk(flags == 16'h0800, "R4", "IF TF cleared", 20'(flags), 20'h0800);
    chk(cs == 16'hABCD && ip == 16'h1234, "R5", "vector cs:ip", {cs, 4'b0}, {16'hABCD, 4'b0});

    // R6: return restores all flags, zero-wait
    cur_tag = "R6"; wait_n = 0;
    memw[20'h10000] = 16'h0777; memw[20'h10002] = 16'h5555; memw[20'h10004] = 16'h0F3F;
    start(0, 1, 16'h0000, 16'h1000, 16'h0, 16'h0, 16'h0000);
    finish_op();
    chk(ip == 16'h0777 && cs == 16'h5555, "R6", "ip cs restored", 20'(ip), 20'h0777);
    chk(flags == 16'h0F3F, "R6", "flags replaced incl IF TF", 20'(flags), 20'h0F3F);
    chk(sp == 16'h0006, "R6", "sp raised by 6", 20'(sp), 20'h0006);

    // R10: wrap on push and pop
    cur_tag = "R10"; wait_n = 1;
    start(1, 0, 16'h0002, 16'h0300, 16'h4444, 16'h5555, 16'h0800);
    finish_op();
    chk(sp == 16'hFFFC, "R10", "push wraps", 20'(sp), 20'hFFFC);
    chk(memw[20'h03000] == 16'h0800 && memw[20'h12FFE] == 16'h4444, "R10", "wrapped save slots",
        memw[20'h12FFE], 16'h4444);
    start(0, 1, 16'hFFFC, 16'h0300, 16'h0, 16'h0, 16'h0);
    finish_op();
    chk(sp == 16'h0002 && flags == 16'h0800, "R10", "pop wraps", 20'(sp), 20'h0002);

    // R9: both at once, entry wins
    cur_tag = "R9"; wait_n = 0;
    start(1, 1, 16'h0200, 16'h0000, 16'h0101, 16'h0202, 16'h0A00);
    finish_op();
    chk(memw[20'h001FE] == 16'h0A00 && sp == 16'h01FA, "R9", "entry chosen", 20'(sp), 20'h01FA);

    // R8: command while busy is ignored
    cur_tag = "R8"; wait_n = 3;
    start(1, 0, 16'h0400, 16'h0000, 16'h0909, 16'h0808, 16'h0800);
    return_req = 1; entry_req = 1;
    @(negedge clk);
    return_req = 0; entry_req = 0;
    finish_op();
    chk(sp == 16'h03FA && ip == 16'h1234 && !busy, "R8", "busy command ignored", 20'(sp), 20'h03FA);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule